// File: doc/BRIEF.md
# Supply Loss Confirmation Sampler

This block decides whether an external supply has truly collapsed before a power sequencer acts on it. A single glitch on the supply-down indicator should not trigger a shutdown, so the block takes a string of samples at a fixed spacing and raises its flag only after enough of them in a row report the supply as missing. Time is counted in strobes of a slow timebase (8192 Hz in the intended system). With the default interval of 2048 strobes, the samples are 250 ms apart.

A sampling run starts on a one-cycle trigger strobe. The trigger comes from an edge seen on the sense line, or from the sequencer when it wants confirmation after power-up because the supply has not appeared. Each sample that sees the supply down adds one to a confirmation count and schedules the next sample one interval later. A sample that sees the supply present ends the run and zeroes the count. When the count has reached its limit, the next scheduled sample sets a sticky flag. The sequencer lowers that flag with a clear strobe whenever it powers the system up or down. All pins are plain control and status levels or strobes. There is no streaming interface and no back-pressure.

Top module: `supply_loss_confirm`

## Requirements
- R1: After reset, `down_flag` is 0, no run is active and the confirmation count is zero.
- R2: A run's first sample is taken on the INTERVAL_TICKS-th cycle with `tick` high that follows the trigger cycle. A `tick` in the trigger cycle is not counted, and cycles with `tick` low do not advance the schedule.
- R3: `supply_down` = 1 means the supply is down. While the count is below CONFIRM_COUNT, a sample that sees `supply_down` = 1 increments the count and schedules the next sample INTERVAL_TICKS ticks later. The first sample after the count reaches CONFIRM_COUNT sets `down_flag` on that clock edge, zeroes the count and ends the run. That sample sets the flag whatever the level is. With the supply down throughout, the flag therefore rises on the (CONFIRM_COUNT+1)*INTERVAL_TICKS-th tick after the trigger.
- R4: A sample taken while the count is below CONFIRM_COUNT that sees `supply_down` = 0 ends the run, zeroes the count and leaves `down_flag` unchanged. A later trigger starts a full new sequence.
- R5: Without a trigger, no run starts and `down_flag` stays 0, however long `supply_down` is held at 1.
- R6: A trigger during an active run restarts the interval from zero and keeps the confirmation count.
- R7: A trigger in the same cycle as a due sample wins. That sample is discarded: it is neither counted nor checked.
- R8: `down_flag` is a level. Once set, it holds until a cycle with `clear` = 1, and it reads 0 from the following cycle.
- R9: If `clear` and a flag-setting sample fall in the same cycle, `down_flag` is 1 afterwards.
- R10: `clear` affects only the flag. A run in progress continues and can still set the flag later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe of the slow timebase |
| trigger | input | 1 | One-cycle strobe that starts or restarts a sampling run |
| supply_down | input | 1 | Synchronized indicator level, 1 = supply down |
| clear | input | 1 | Strobe from the sequencer that clears the flag |
| down_flag | output | 1 | Sticky confirmed-loss flag |

## Verification
The bound checker watches, on every cycle, that the flag never drops without a clear and never rises outside a run. It also checks that a trigger resets the interval counter while keeping the run alive, that an "up" sample below the limit leaves the block idle with a zero count, and that the counters stay within their bounds. Only the bench scenarios can show the exact edge on which the flag rises. That edge depends on the whole chain of ticks, samples and retriggers: the full confirmation time, a paused timebase, a retrigger that keeps the count, a retrigger that lands on a sample, an abort followed by a fresh sequence, and a set that coincides with a clear.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic {
    RUN_IDLE   = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_t;

  function automatic int cnt_width(input int max_value);
    return (max_value < 2) ? 1 : $clog2(max_value + 1);
  endfunction
endpackage

// File: rtl/slc_interval_timer.sv
module slc_interval_timer
  import slc_pkg::*;
#(
  parameter int INTERVAL_TICKS = 2048,
  localparam int TW = cnt_width(INTERVAL_TICKS - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          trigger,
  input  logic          stop,
  output logic          sample,
  output logic          active,
  output logic [TW-1:0] tick_cnt
);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_TICKS - 1);

  run_state_t state_q;

  assign active = (state_q == RUN_ACTIVE);
  assign sample = active && tick && !trigger && (tick_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RUN_IDLE;
      tick_cnt <= '0;
    end else if (trigger) begin
      state_q  <= RUN_ACTIVE;
      tick_cnt <= '0;
    end else if (active && tick) begin
      if (tick_cnt == LAST) begin
        tick_cnt <= '0;
        if (stop) state_q <= RUN_IDLE;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/slc_confirm_counter.sv
module slc_confirm_counter
  import slc_pkg::*;
#(
  parameter int CONFIRM_COUNT = 6,
  localparam int CW = cnt_width(CONFIRM_COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          level_down,
  output logic          confirmed,
  output logic          stop,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] LIMIT = CW'(CONFIRM_COUNT);

  logic at_limit;

  assign at_limit  = (count == LIMIT);
  assign confirmed = sample && at_limit;
  assign stop      = sample && (at_limit || !level_down);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (sample) begin
      if (at_limit || !level_down) count <= '0;
      else                         count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/slc_flag_reg.sv
module slc_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set)   flag <= 1'b1;
    else if (clear) flag <= 1'b0;
  end
endmodule

// File: rtl/supply_loss_confirm.sv
module supply_loss_confirm
  import slc_pkg::*;
#(
  parameter int INTERVAL_TICKS = 2048,
  parameter int CONFIRM_COUNT  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trigger,
  input  logic supply_down,
  input  logic clear,
  output logic down_flag
);
  localparam int TW = cnt_width(INTERVAL_TICKS - 1);
  localparam int CW = cnt_width(CONFIRM_COUNT);

  logic          sample;
  logic          stop;
  logic          confirmed;
  logic          run_active;
  logic [TW-1:0] tick_cnt;
  logic [CW-1:0] conf_cnt;

  slc_interval_timer #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .trigger  (trigger),
    .stop     (stop),
    .sample   (sample),
    .active   (run_active),
    .tick_cnt (tick_cnt)
  );

  slc_confirm_counter #(.CONFIRM_COUNT(CONFIRM_COUNT)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample     (sample),
    .level_down (supply_down),
    .confirmed  (confirmed),
    .stop       (stop),
    .count      (conf_cnt)
  );

  slc_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (confirmed),
    .clear (clear),
    .flag  (down_flag)
  );
endmodule

// File: rtl/supply_loss_confirm_chk.sv
module supply_loss_confirm_chk
  import slc_pkg::*;
#(
  parameter int INTERVAL_TICKS = 2048,
  parameter int CONFIRM_COUNT  = 6,
  localparam int TW = cnt_width(INTERVAL_TICKS - 1),
  localparam int CW = cnt_width(CONFIRM_COUNT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trigger,
  input logic          supply_down,
  input logic          clear,
  input logic          down_flag,
  input logic          run_active,
  input logic          sample,
  input logic [TW-1:0] tick_cnt,
  input logic [CW-1:0] conf_cnt
);
  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (down_flag && !clear) |=> down_flag);

  assert_flag_falls_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(down_flag) |-> $past(clear));

  assert_flag_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(down_flag) |-> $past(run_active));

  assert_retrigger_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (run_active && tick_cnt == '0));

  assert_up_sample_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !supply_down && conf_cnt < CW'(CONFIRM_COUNT)) |=> (!run_active && conf_cnt == '0));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conf_cnt <= CW'(CONFIRM_COUNT));

  assert_interval_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= TW'(INTERVAL_TICKS - 1));
endmodule

bind supply_loss_confirm supply_loss_confirm_chk #(
  .INTERVAL_TICKS (INTERVAL_TICKS),
  .CONFIRM_COUNT  (CONFIRM_COUNT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trigger     (trigger),
  .supply_down (supply_down),
  .clear       (clear),
  .down_flag   (down_flag),
  .run_active  (run_active),
  .sample      (sample),
  .tick_cnt    (tick_cnt),
  .conf_cnt    (conf_cnt)
);

// File: tb/test_supply_loss_confirm.sv
module test_supply_loss_confirm;
  localparam int IV  = 8;
  localparam int CC  = 6;
  localparam int FULL = (CC + 1) * IV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic trigger = 1'b0;
  logic supply_down = 1'b0;
  logic clear = 1'b0;
  logic down_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  supply_loss_confirm #(.INTERVAL_TICKS(IV), .CONFIRM_COUNT(CC)) i_supply_loss_confirm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trigger(trigger),
    .supply_down(supply_down), .clear(clear), .down_flag(down_flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: down_flag=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; trigger is seen by the next posedge (E0)
  task automatic pulse_trigger();
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  task automatic pulse_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", down_flag, 1'b0);
  endtask

  task automatic t_idle_down();
    supply_down = 1'b1;
    wait_n(100);
    check("R5 no trigger", down_flag, 1'b0);
  endtask

  task automatic t_full_run();
    supply_down = 1'b1;
    pulse_trigger();
    wait_n(FULL - 1);
    check("R3 before confirm", down_flag, 1'b0);
    wait_n(1);
    check("R3 confirm edge", down_flag, 1'b1);
    wait_n(100);
    check("R8 flag holds", down_flag, 1'b1);
    pulse_clear();
    check("R8 cleared", down_flag, 1'b0);
    wait_n(3 * IV);
    check("R8 stays clear after run", down_flag, 1'b0);
  endtask

  task automatic t_tick_gate();
    supply_down = 1'b1;
    tick = 1'b0;
    pulse_trigger();
    wait_n(29);
    tick = 1'b1;
    wait_n(FULL - 1);
    check("R2 paused ticks before", down_flag, 1'b0);
    wait_n(1);
    check("R2 paused ticks edge", down_flag, 1'b1);
    pulse_clear();
  endtask

  task automatic t_abort();
    supply_down = 1'b1;
    pulse_trigger();
    wait_n(3 * IV);
    supply_down = 1'b0;
    wait_n(200);
    check("R4 up sample aborts", down_flag, 1'b0);
    supply_down = 1'b1;
    wait_n(100);
    check("R4 no resume without trigger", down_flag, 1'b0);
    pulse_trigger();
    wait_n(FULL - 1);
    check("R4 fresh sequence before", down_flag, 1'b0);
    wait_n(1);
    check("R4 fresh sequence edge", down_flag, 1'b1);
    pulse_clear();
  endtask

  task automatic t_retrigger();
    supply_down = 1'b1;
    pulse_trigger();
    wait_n(2 * IV + 3);
    pulse_trigger();
    wait_n((CC - 1) * IV - 1);
    check("R6 count kept before", down_flag, 1'b0);
    wait_n(1);
    check("R6 count kept edge", down_flag, 1'b1);
    pulse_clear();
  endtask

  task automatic t_coincide();
    supply_down = 1'b1;
    pulse_trigger();
    wait_n(2 * IV - 1);
    pulse_trigger();
    wait_n(CC * IV - 1);
    check("R7 discarded sample before", down_flag, 1'b0);
    wait_n(1);
    check("R7 discarded sample edge", down_flag, 1'b1);
    pulse_clear();
  endtask

  task automatic t_clear_in_run();
    supply_down = 1'b1;
    pulse_trigger();
    wait_n(19);
    pulse_clear();
    wait_n(FULL - 21);
    check("R10 run survives clear", down_flag, 1'b0);
    pulse_clear();
    check("R9 set beats clear", down_flag, 1'b1);
    pulse_clear();
    check("R8 clear after R9", down_flag, 1'b0);
  endtask

  initial begin
    #150000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_idle_down();
    t_full_run();
    t_tick_gate();
    t_abort();
    t_retrigger();
    t_coincide();
    t_clear_in_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule